// File: doc/BRIEF.md
# Barrel Shifter with Flag Generation

This block is the shift and rotate stage of a 32-bit processor datapath. In a single combinational pass it takes an operand, a shift amount, an operation code and the current N, Z and C flags. It produces the shifted result and the next value of each of those three flags. The operations are logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. The amount comes either from a 5-bit immediate field or from the whole low byte of a register value, so the amount ranges over 0 to 255. The carry-out is exact for every amount in that range.

When the flag-update enable is high, N and Z come from the result and C becomes the last bit shifted out of the operand. When the enable is low, the three next-flag outputs repeat the current flags. A small flag register captures the next flags on a rising clock edge, and only when the enable is high. It drives them back out as registered flags. The V flag is not part of this unit.

The datapath carries no stream traffic: each input set produces its outputs in the same cycle. For that reason the ports are plain and have no valid/ready handshake, and the unit applies no back-pressure.

Top module: `bs_shift_unit`

## Requirements
- R1: With `amt_from_reg`=0 the shift amount is `imm_amt` (0 to 31). With `amt_from_reg`=1 it is `reg_amt` (0 to 255).
- R2: For every operation except RRX, an amount of 0 gives `result` = `operand` and `nxt_c` = `cur_c`.
- R3: LSL (`op`=0) by n, with 1 ≤ n ≤ 32, gives `operand` << n, and its carry is `operand[32-n]`. At n = 32 the result is 0 and the carry is `operand[0]`.
- R4: LSR (`op`=1) by n, with 1 ≤ n ≤ 32, gives `operand` >> n, and its carry is `operand[n-1]`. At n = 32 the result is 0 and the carry is `operand[31]`.
- R5: LSL or LSR by more than 32 gives a result of 0 and a carry of 0.
- R6: ASR (`op`=2) by n with 1 ≤ n ≤ 31 shifts in copies of bit 31, and its carry is `operand[n-1]`. For n ≥ 32 every result bit and the carry equal `operand[31]`.
- R7: ROR (`op`=3) rotates by n mod 32, and its carry is result bit 31 whenever n ≠ 0. A nonzero multiple of 32 returns the operand unchanged.
- R8: RRX (`op`=4) ignores the amount and gives {`cur_c`, `operand[31:1]`}, with carry `operand[0]`.
- R9: With `set_flags`=1, `nxt_n` is `result[31]`, `nxt_z` is 1 exactly when `result` is 0, and `nxt_c` is the carry described above.
- R10: With `set_flags`=0, `nxt_n`, `nxt_z` and `nxt_c` equal `cur_n`, `cur_z` and `cur_c`.
- R11: `flag_n`, `flag_z` and `flag_c` reset to 0. On a rising clock edge with `set_flags`=1 they load `nxt_n`, `nxt_z` and `nxt_c`. Otherwise they hold.
- R12: Op codes 5, 6 and 7 pass the operand through unchanged, with a carry of `cur_c`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 32 | Value to shift |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Low byte of a register holding the amount |
| amt_from_reg | input | 1 | 1 selects `reg_amt`, 0 selects `imm_amt` |
| op | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| set_flags | input | 1 | Flag-update enable |
| cur_n | input | 1 | Current N flag |
| cur_z | input | 1 | Current Z flag |
| cur_c | input | 1 | Current C flag |
| result | output | 32 | Shift result |
| nxt_n | output | 1 | Next N flag |
| nxt_z | output | 1 | Next Z flag |
| nxt_c | output | 1 | Next C flag |
| flag_n | output | 1 | Registered N flag |
| flag_z | output | 1 | Registered Z flag |
| flag_c | output | 1 | Registered C flag |

## Verification
The bench concentrates on the amount boundaries 0, 1, 31, 32, 33 and 255 for every shift type.

- **Amount 0.** A design that treated 0 as an ordinary shift would clear or corrupt the carry.
- **Amount 32.** An off-by-one in the carry index would show up here as the wrong carry bit.
- **Amounts above 32.** Truncating a register amount to 5 bits would turn a shift of 33 into a shift of 1.
- **ROR at multiples of 32.** These amounts must return the operand unchanged while still producing a carry equal to bit 31.
- **RRX.** Both values of the incoming carry are driven. This catches a design that ignores the old carry or applies the amount to RRX.
- **Flag enable off.** Cycles with the enable low confirm that neither the next flags nor the registered flags move.

// File: rtl/bs_pkg.sv
package bs_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 5;
  localparam int unsigned AMT_W  = 8;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shop_e;
endpackage

// File: rtl/bs_amount.sv
module bs_amount #(
  parameter int unsigned IMM_W = 5,
  parameter int unsigned AMT_W = 8
) (
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  input  logic             from_reg,
  output logic [AMT_W-1:0] amt
);
  localparam int unsigned PAD_W = AMT_W - IMM_W;

  always_comb begin
    if (from_reg) amt = reg_amt;
    else          amt = {{PAD_W{1'b0}}, imm_amt};
  end
endmodule

// File: rtl/bs_core.sv
module bs_core
  import bs_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [DW-1:0]    a,
  input  logic [AMT_W-1:0] amt,
  input  logic [OP_W-1:0]  op,
  input  logic             cin,
  output logic [DW-1:0]    res,
  output logic             cout
);
  localparam int unsigned RW = $clog2(DW);

  shop_e         opc;
  logic [DW:0]   lsl_w;
  logic [DW:0]   lsr_w;
  logic [DW:0]   asr_w;
  logic [DW-1:0] ror_w;
  logic [RW-1:0] rot;
  logic          amt_zero;

  assign opc      = shop_e'(op);
  assign amt_zero = (amt == '0);
  assign rot      = amt[RW-1:0];

  // One extra bit carries the last bit shifted out of the operand.
  assign lsl_w = {1'b0, a} << amt;
  assign lsr_w = {a, 1'b0} >> amt;
  assign asr_w = $signed({a, 1'b0}) >>> amt;
  assign ror_w = (a >> rot) | (a << (DW - rot));

  always_comb begin
    res  = a;
    cout = cin;
    unique case (opc)
      OP_LSL: if (!amt_zero) begin res = lsl_w[DW-1:0]; cout = lsl_w[DW]; end
      OP_LSR: if (!amt_zero) begin res = lsr_w[DW:1];   cout = lsr_w[0];  end
      OP_ASR: if (!amt_zero) begin res = asr_w[DW:1];   cout = asr_w[0];  end
      OP_ROR: if (!amt_zero) begin res = ror_w;         cout = ror_w[DW-1]; end
      OP_RRX: begin res = {cin, a[DW-1:1]}; cout = a[0]; end
      default: begin res = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/bs_flags.sv
module bs_flags #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] res,
  input  logic          cout,
  input  logic          set_flags,
  input  logic          cur_n,
  input  logic          cur_z,
  input  logic          cur_c,
  output logic          nxt_n,
  output logic          nxt_z,
  output logic          nxt_c,
  output logic          q_n,
  output logic          q_z,
  output logic          q_c
);
  always_comb begin
    if (set_flags) begin
      nxt_n = res[DW-1];
      nxt_z = (res == '0);
      nxt_c = cout;
    end else begin
      nxt_n = cur_n;
      nxt_z = cur_z;
      nxt_c = cur_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_n <= 1'b0;
      q_z <= 1'b0;
      q_c <= 1'b0;
    end else if (set_flags) begin
      q_n <= nxt_n;
      q_z <= nxt_z;
      q_c <= nxt_c;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable({q_n, q_z, q_c}));

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> {q_n, q_z, q_c} == $past({nxt_n, nxt_z, nxt_c}));
endmodule

// File: rtl/bs_shift_unit.sv
module bs_shift_unit
  import bs_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    operand,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  input  logic             amt_from_reg,
  input  logic [OP_W-1:0]  op,
  input  logic             set_flags,
  input  logic             cur_n,
  input  logic             cur_z,
  input  logic             cur_c,
  output logic [DW-1:0]    result,
  output logic             nxt_n,
  output logic             nxt_z,
  output logic             nxt_c,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c
);
  logic [AMT_W-1:0] amt;
  logic             cout;

  bs_amount #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .from_reg(amt_from_reg),
    .amt     (amt)
  );

  bs_core #(.DW(DW), .AMT_W(AMT_W)) u_core (
    .a   (operand),
    .amt (amt),
    .op  (op),
    .cin (cur_c),
    .res (result),
    .cout(cout)
  );

  bs_flags #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .res      (result),
    .cout     (cout),
    .set_flags(set_flags),
    .cur_n    (cur_n),
    .cur_z    (cur_z),
    .cur_c    (cur_c),
    .nxt_n    (nxt_n),
    .nxt_z    (nxt_z),
    .nxt_c    (nxt_c),
    .q_n      (flag_n),
    .q_z      (flag_z),
    .q_c      (flag_c)
  );

  p_zero_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (amt == '0 && op != OP_RRX) |-> (result == operand && nxt_c == cur_c));

  p_far_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_LSL || op == OP_LSR) && amt > AMT_W'(DW)) |->
      (result == '0 && (!set_flags || !nxt_c)));

  p_asr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ASR && amt >= AMT_W'(DW)) |-> (result == {DW{operand[DW-1]}}));

  p_rrx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RRX) |-> (result == {cur_c, operand[DW-1:1]}));

  p_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |-> (nxt_n == result[DW-1] && nxt_z == (result == '0)));
endmodule

// File: tb/tb_bs_shift_unit.sv
`timescale 1ns/1ps
module tb_bs_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        amt_from_reg = 1'b0;
  logic [2:0]  op = '0;
  logic        set_flags = 1'b0;
  logic        cur_n = 1'b0, cur_z = 1'b0, cur_c = 1'b0;
  logic [31:0] result;
  logic        nxt_n, nxt_z, nxt_c, flag_n, flag_z, flag_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bs_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .amt_from_reg(amt_from_reg), .op(op),
    .set_flags(set_flags), .cur_n(cur_n), .cur_z(cur_z), .cur_c(cur_c),
    .result(result), .nxt_n(nxt_n), .nxt_z(nxt_z), .nxt_c(nxt_c),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  typedef struct packed {
    logic [31:0] r;
    logic        n, z, c, qn, qz, qc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  mq_n = 1'b0, mq_z = 1'b0, mq_c = 1'b0;

  function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [7:0] n, input logic ci);
    logic [31:0] r;
    logic        c;
    r = a;
    c = ci;
    case (o)
      3'd0: for (int i = 0; i < int'(n); i++) begin c = r[31]; r = r << 1; end
      3'd1: for (int i = 0; i < int'(n); i++) begin c = r[0];  r = r >> 1; end
      3'd2: for (int i = 0; i < int'(n); i++) begin c = r[0];  r = {r[31], r[31:1]}; end
      3'd3: for (int i = 0; i < int'(n); i++) begin c = r[0];  r = {r[0], r[31:1]}; end
      3'd4: begin c = a[0]; r = {ci, a[31:1]}; end
      default: ;
    endcase
    return {c, r};
  endfunction

  task automatic drive(input string tag, input logic [2:0] o, input logic [31:0] a,
                       input logic [4:0] imm, input logic [7:0] rb, input logic sel,
                       input logic set, input logic cn, input logic cz, input logic cc);
    logic [32:0] m;
    logic [7:0]  n;
    exp_t        e;
    @(posedge clk);
    #1;
    op = o; operand = a; imm_amt = imm; reg_amt = rb; amt_from_reg = sel;
    set_flags = set; cur_n = cn; cur_z = cz; cur_c = cc;
    n = sel ? rb : {3'b000, imm};
    m = model(o, a, n, cc);
    e.r  = m[31:0];
    e.n  = set ? m[31] : cn;
    e.z  = set ? (m[31:0] == 32'd0) : cz;
    e.c  = set ? m[32] : cc;
    e.qn = mq_n; e.qz = mq_z; e.qc = mq_c;
    if (set) begin mq_n = e.n; mq_z = e.z; mq_c = e.c; end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {result, nxt_n, nxt_z, nxt_c, flag_n, flag_z, flag_c};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got r=%h nzc=%b%b%b q=%b%b%b exp r=%h nzc=%b%b%b q=%b%b%b",
                 t, g.r, g.n, g.z, g.c, g.qn, g.qz, g.qc,
                 e.r, e.n, e.z, e.c, e.qn, e.qz, e.qc);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({flag_n, flag_z, flag_c} !== 3'b000) begin
      fails++;
      $display("FAIL R11 reset: got %b%b%b exp 000", flag_n, flag_z, flag_c);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    v = 32'hC000_0005;
    // R1: immediate versus register amount
    drive("R1", 3'd1, v, 5'd4, 8'd40, 1'b0, 1'b1, 0, 0, 0);
    drive("R1", 3'd1, v, 5'd4, 8'd40, 1'b1, 1'b1, 0, 0, 0);
    drive("R1", 3'd0, v, 5'd31, 8'd2, 1'b1, 1'b1, 0, 0, 1);
    // R2: amount 0 for each shift type, both carry values
    for (int o = 0; o < 4; o++) begin
      drive("R2", 3'(o), v, 5'd0, 8'd0, 1'b0, 1'b1, 0, 0, 1);
      drive("R2", 3'(o), v, 5'd0, 8'd0, 1'b1, 1'b1, 1, 1, 0);
    end
    // R3/R4: 1, 31, 32
    drive("R3", 3'd0, v, 5'd1, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R3", 3'd0, v, 5'd31, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R3", 3'd0, 32'h0000_0001, 5'd0, 8'd32, 1'b1, 1'b1, 0, 0, 0);
    drive("R4", 3'd1, v, 5'd1, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R4", 3'd1, v, 5'd31, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R4", 3'd1, v, 5'd0, 8'd32, 1'b1, 1'b1, 0, 0, 0);
    // R5: beyond 32
    drive("R5", 3'd0, 32'hFFFF_FFFF, 5'd0, 8'd33, 1'b1, 1'b1, 0, 0, 1);
    drive("R5", 3'd1, 32'hFFFF_FFFF, 5'd0, 8'd33, 1'b1, 1'b1, 0, 0, 1);
    drive("R5", 3'd0, 32'hFFFF_FFFF, 5'd0, 8'd255, 1'b1, 1'b1, 0, 0, 1);
    drive("R5", 3'd1, 32'hFFFF_FFFF, 5'd0, 8'd255, 1'b1, 1'b1, 0, 0, 1);
    // R6: arithmetic right
    drive("R6", 3'd2, 32'h8000_0010, 5'd5, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R6", 3'd2, 32'h8000_0010, 5'd0, 8'd32, 1'b1, 1'b1, 0, 0, 0);
    drive("R6", 3'd2, 32'h7000_0010, 5'd0, 8'd200, 1'b1, 1'b1, 0, 0, 1);
    drive("R6", 3'd2, 32'h8000_0000, 5'd0, 8'd255, 1'b1, 1'b1, 0, 0, 0);
    // R7: rotate right
    drive("R7", 3'd3, v, 5'd3, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    drive("R7", 3'd3, v, 5'd0, 8'd32, 1'b1, 1'b1, 0, 0, 0);
    drive("R7", 3'd3, 32'h7FFF_FFFF, 5'd0, 8'd64, 1'b1, 1'b1, 0, 0, 1);
    drive("R7", 3'd3, v, 5'd0, 8'd35, 1'b1, 1'b1, 0, 0, 0);
    // R8: rotate through carry, amount ignored
    drive("R8", 3'd4, v, 5'd7, 8'd0, 1'b0, 1'b1, 0, 0, 1);
    drive("R8", 3'd4, v, 5'd0, 8'd99, 1'b1, 1'b1, 0, 0, 0);
    drive("R8", 3'd4, 32'h0000_0001, 5'd0, 8'd0, 1'b0, 1'b1, 0, 0, 0);
    // R9: zero result sets Z
    drive("R9", 3'd1, 32'h0000_0001, 5'd1, 8'd0, 1'b0, 1'b1, 1, 0, 0);
    drive("R9", 3'd0, 32'h4000_0000, 5'd1, 8'd0, 1'b0, 1'b1, 0, 1, 0);
    // R10/R11: flag update disabled, registered flags hold
    drive("R10", 3'd0, v, 5'd4, 8'd0, 1'b0, 1'b0, 1, 0, 1);
    drive("R10", 3'd2, 32'h8000_0001, 5'd1, 8'd0, 1'b0, 1'b0, 0, 1, 0);
    drive("R11", 3'd3, v, 5'd1, 8'd0, 1'b0, 1'b0, 1, 1, 1);
    drive("R11", 3'd4, v, 5'd0, 8'd0, 1'b0, 1'b1, 0, 0, 1);
    // R12: undefined op codes
    for (int o = 5; o < 8; o++)
      drive("R12", 3'(o), v, 5'd9, 8'd77, 1'b1, 1'b1, 0, 0, 1);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra;
      int         pick;
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: ra = 8'd0;
        1: ra = 8'd1;
        2: ra = 8'd31;
        3: ra = 8'd32;
        4: ra = 8'd33;
        default: ra = 8'($urandom);
      endcase
      drive("R9", 3'($urandom_range(0, 7)), $urandom, 5'($urandom), ra,
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule